// File: doc/BRIEF.md
# System Control Register File

This block is the global control register set of a small microcontroller. It sits on a 32-bit register bus and decodes a 1 KB window (10 address bits). Only whole, word-aligned 32-bit accesses are valid, and the byte order is little-endian. It holds the following registers, each with a fixed value after reset:

- system control
- clock control
- power management
- clock divide
- two peripheral clock-gate registers
- memory configuration
- event enable
- interrupt enable
- revision
- four ECC status and control words

Two registers have write side effects. The system-control register keeps only a two-bit field and forces two status bits, so an integrity checksum always reads as finished and good. The clock-control register always reads with its ready bit set.

Two more registers store nothing. A write to the reset-control register becomes one-cycle reset pulses, one per peripheral. Two command bits expand into fixed peripheral groups, and a third command bit raises a whole-system reset request. A write to the zeroize register becomes one-cycle clear requests for four RAM banks of 32 KB, 32 KB, 48 KB and 16 KB. The RAM clearing, the clocks and the peripherals sit outside this block. It only drives the request and reset lines.

The block has an asynchronous active-low reset. An internal two-flop synchronizer releases it, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, the stored registers read back the following values, at the byte offsets shown:

  | Register | Offset | Reset value |
  |---|---|---|
  | System control | 0x00 | 0x00021002 |
  | Clock control | 0x04 | 0x3E140008 |
  | Power management | 0x08 | 0x0003F000 |
  | Clock divide | 0x0C | 0x00000000 |
  | Clock gate 0 | 0x10 | 0xFFFFFFFF |
  | Clock gate 1 | 0x14 | 0xFFFFFFFF |
  | Memory configuration | 0x18 | 0x00000005 |
  | Event enable | 0x1C | 0x00000000 |
  | Interrupt enable | 0x20 | 0x00000000 |
  | Revision | 0x24 | 0x000000A1 |
  | ECC words | 0x28, 0x2C, 0x30, 0x34 | 0x00000000 |
- R2: The registers at offsets 0x08 through 0x34 store all 32 written bits unchanged, and each reads back exactly what was last written.
- R3: A write to system control (0x00) keeps written bits 17:16, clears all other written bits, and forces bits 12 and 1 to one.
- R4: A write to clock control (0x04) stores the written value with the ready bit (bit 25) forced to one.
- R5: A write to reset control (0x40) drives `periph_rst[k]` high for exactly one cycle for each set written bit k in 28:0. The pulse appears on the clock edge that accepts the write. Reset control always reads back zero.
- R6: If written bit 30 (peripheral group) is set, the plain bits are replaced by the peripheral group mask 0x170359E3. This mask is DMA 0, watchdog 1, timers 5 to 8, UARTs 11, 12 and 28, SPI 14, I2C 16, RTC 17, TRNG 24, accelerator 25 and ADC 26. It leaves out GPIO bits 2 and 3.
- R7: If written bit 29 (soft group) is set, the pulse set is 0x170359ED. This is the peripheral group without watchdog bit 1 and with GPIO bits 2 and 3. The soft group wins when bits 29 and 30 are both set.
- R8: Written bit 31 of reset control raises `sys_rst_req` for one cycle. It does this whatever the other bits are, and it pulses no peripheral by itself.
- R9: A write to the zeroize register (0x44) drives `zero_req[b]` high for one cycle for each set written bit b in 3:0. The register reads back zero.
- R10: A read from an unmapped offset (0x38 to 0x3C, or 0x48 and above) returns zero. A read from any offset with bits 1:0 not zero also returns zero. A write to any of these offsets changes no register and raises no pulse.
- R11: Read data and `bus_rvalid` appear one cycle after the read is accepted. `bus_rvalid` is low in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| sys_rst_req | output | 1 | One-cycle whole-system reset request |
| periph_rst | output | 29 | One-cycle per-peripheral reset pulses |
| zero_req | output | 4 | One-cycle per-bank RAM clear requests |

## Verification
Every result is due exactly one clock edge after the access is accepted:

- read data and its valid flag;
- a stored value being visible to a following read;
- the reset, system-request and zeroize pulses, which fall again on the next edge.

The bench drives each access on a falling edge and samples on the next falling edge, halfway after the edge that produces the result. It then takes one more falling-edge sample to confirm that each pulse lasted a single cycle. The reset check reads only after waiting out the two-edge reset synchronizer.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int DATA_W      = 32;
  localparam int NUM_STORE   = 14;
  localparam int IDX_SYS     = 0;
  localparam int IDX_CLK     = 1;
  localparam int WORD_RSTCTL = 16;
  localparam int WORD_ZERO   = 17;
  localparam int CLK_RDY_BIT = 25;

  localparam logic [DATA_W-1:0] SYS_KEEP  = 32'h0003_0000;
  localparam logic [DATA_W-1:0] SYS_FORCE = 32'h0000_1002;

  // Reset-control bit positions (decoded by the peripherals)
  localparam int RB_DMA   = 0;
  localparam int RB_WDT   = 1;
  localparam int RB_GPIO0 = 2;
  localparam int RB_GPIO1 = 3;
  localparam int RB_TMR0  = 5;
  localparam int RB_UART0 = 11;
  localparam int RB_UART1 = 12;
  localparam int RB_SPI   = 14;
  localparam int RB_I2C   = 16;
  localparam int RB_RTC   = 17;
  localparam int RB_TRNG  = 24;
  localparam int RB_ACC   = 25;
  localparam int RB_ADC   = 26;
  localparam int RB_UART2 = 28;
  localparam int RB_SOFT  = 29;
  localparam int RB_GROUP = 30;
  localparam int RB_SYS   = 31;

  function automatic logic [DATA_W-1:0] reset_value(int idx);
    case (idx)
      0:       return 32'h0002_1002;
      1:       return 32'h3E14_0008;
      2:       return 32'h0003_F000;
      4, 5:    return 32'hFFFF_FFFF;
      6:       return 32'h0000_0005;
      9:       return 32'h0000_00A1;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] filter_write(int idx, logic [DATA_W-1:0] d);
    if (idx == IDX_SYS)      return (d & SYS_KEEP) | SYS_FORCE;
    else if (idx == IDX_CLK) return d | (32'd1 << CLK_RDY_BIT);
    else                     return d;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int NSTORE = NUM_STORE
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [NSTORE-1:0] store_we,
  output logic [NSTORE-1:0] store_rd,
  output logic              rstctl_we,
  output logic              zero_we
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              do_wr;
  logic              do_rd;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign do_wr   = sel & wr & aligned;
  assign do_rd   = sel & ~wr & aligned;

  for (genvar i = 0; i < NSTORE; i++) begin : g_dec
    assign store_we[i] = do_wr & (word == WORD_W'(i));
    assign store_rd[i] = do_rd & (word == WORD_W'(i));
  end

  assign rstctl_we = do_wr & (word == WORD_W'(WORD_RSTCTL));
  assign zero_we   = do_wr & (word == WORD_W'(WORD_ZERO));

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int NSTORE = NUM_STORE
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSTORE-1:0]            we,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NSTORE-1:0][DATA_W-1:0] q
);

  for (genvar i = 0; i < NSTORE; i++) begin : g_reg
    logic [DATA_W-1:0] q_nxt;

    always_comb begin
      q_nxt = q[i];
      if (we[i]) q_nxt = filter_write(i, wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= reset_value(i);
      else if (we[i]) q[i] <= q_nxt;
    end
  end

  assert_sys_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we[IDX_SYS] |=> (q[IDX_SYS][17:16] == $past(wdata[17:16])) && q[IDX_SYS][12]
                    && q[IDX_SYS][1] && (q[IDX_SYS][15:13] == 3'b000));

  assert_clk_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we[IDX_CLK] |=> q[IDX_CLK][CLK_RDY_BIT]);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |=> $stable(q));

endmodule

// File: rtl/sysctl_pulse_gen.sv
module sysctl_pulse_gen
  import sysctl_pkg::*;
#(
  parameter int RST_W     = 29,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rstctl_we,
  input  logic                 zero_we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [RST_W-1:0]     periph_rst,
  output logic                 sys_rst_req,
  output logic [NUM_BANKS-1:0] zero_req
);
  localparam logic [DATA_W-1:0] GROUP_FULL =
      (32'd1 << RB_DMA)   | (32'd1 << RB_WDT)   | (32'hF << RB_TMR0) |
      (32'd1 << RB_UART0) | (32'd1 << RB_UART1) | (32'd1 << RB_UART2) |
      (32'd1 << RB_SPI)   | (32'd1 << RB_I2C)   | (32'd1 << RB_RTC)  |
      (32'd1 << RB_TRNG)  | (32'd1 << RB_ACC)   | (32'd1 << RB_ADC);
  localparam logic [DATA_W-1:0] SOFT_FULL =
      (GROUP_FULL & ~(32'd1 << RB_WDT)) | (32'd1 << RB_GPIO0) | (32'd1 << RB_GPIO1);
  localparam logic [RST_W-1:0] GROUP_MASK = GROUP_FULL[RST_W-1:0];
  localparam logic [RST_W-1:0] SOFT_MASK  = SOFT_FULL[RST_W-1:0];

  logic [RST_W-1:0]     rst_nxt;
  logic                 sys_nxt;
  logic [NUM_BANKS-1:0] zero_nxt;

  always_comb begin
    rst_nxt  = '0;
    sys_nxt  = 1'b0;
    zero_nxt = '0;
    if (rstctl_we) begin
      sys_nxt = wdata[RB_SYS];
      rst_nxt = wdata[RST_W-1:0];
      if (wdata[RB_GROUP]) rst_nxt = GROUP_MASK;
      if (wdata[RB_SOFT])  rst_nxt = SOFT_MASK;
    end
    if (zero_we) zero_nxt = wdata[NUM_BANKS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      periph_rst  <= '0;
      sys_rst_req <= 1'b0;
      zero_req    <= '0;
    end else begin
      periph_rst  <= rst_nxt;
      sys_rst_req <= sys_nxt;
      zero_req    <= zero_nxt;
    end
  end

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rstctl_we |=> (periph_rst == '0) && !sys_rst_req);

  assert_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rstctl_we && wdata[RB_GROUP] && !wdata[RB_SOFT]) |=>
      periph_rst[RB_WDT] && !periph_rst[RB_GPIO0] && !periph_rst[RB_GPIO1]);

  assert_soft_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rstctl_we && wdata[RB_SOFT]) |=>
      !periph_rst[RB_WDT] && periph_rst[RB_GPIO0] && periph_rst[RB_GPIO1]);

  assert_sys_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rstctl_we && wdata[RB_SYS]) |=> sys_rst_req);

  assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_we |=> (zero_req == '0));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int RST_W     = 29,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_rvalid,
  output logic                 sys_rst_req,
  output logic [RST_W-1:0]     periph_rst,
  output logic [NUM_BANKS-1:0] zero_req
);
  localparam int WORD_W = ADDR_W - 2;

  // Reset synchronizer: asserts at once, releases on the second edge
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NUM_STORE-1:0]             store_we;
  logic [NUM_STORE-1:0]             store_rd;
  logic                             rstctl_we;
  logic                             zero_we;
  logic [NUM_STORE-1:0][DATA_W-1:0] store_q;

  sysctl_decode #(.ADDR_W(ADDR_W), .NSTORE(NUM_STORE)) i_decode (
    .sel       (bus_sel),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .store_we  (store_we),
    .store_rd  (store_rd),
    .rstctl_we (rstctl_we),
    .zero_we   (zero_we)
  );

  sysctl_store #(.NSTORE(NUM_STORE)) i_store (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (store_we),
    .wdata (bus_wdata),
    .q     (store_q)
  );

  sysctl_pulse_gen #(.RST_W(RST_W), .NUM_BANKS(NUM_BANKS)) i_pulse (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rstctl_we   (rstctl_we),
    .zero_we     (zero_we),
    .wdata       (bus_wdata),
    .periph_rst  (periph_rst),
    .sys_rst_req (sys_rst_req),
    .zero_req    (zero_req)
  );

  // Read path: one-hot select of the stored words, zero elsewhere
  logic [DATA_W-1:0] rdata_nxt;
  logic              rd_accept;

  assign rd_accept = bus_sel & ~bus_wr;

  always_comb begin
    rdata_nxt = '0;
    for (int i = 0; i < NUM_STORE; i++) begin
      if (store_rd[i]) rdata_nxt = rdata_nxt | store_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_accept;
      if (rd_accept) bus_rdata <= rdata_nxt;
    end
  end

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_accept && ((bus_addr[1:0] != 2'b00) ||
                   (bus_addr[ADDR_W-1:2] >= WORD_W'(NUM_STORE)))) |=> (bus_rdata == '0));

  assert_misaligned_quiet_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && (bus_addr[1:0] != 2'b00)) |=>
      (periph_rst == '0) && !sys_rst_req && (zero_req == '0));

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({store_we, rstctl_we, zero_we}));

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_accept |=> bus_rvalid);

  assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_accept |=> !bus_rvalid);

endmodule

// File: tb/test_sysctl_regfile.sv
module test_sysctl_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        sys_rst_req;
  logic [28:0] periph_rst;
  logic [3:0]  zero_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  sysctl_regfile i_sysctl_regfile (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .sys_rst_req (sys_rst_req),
    .periph_rst  (periph_rst),
    .zero_req    (zero_req)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{8'd3,  10'h000, 32'hFFFF_FFFF, 32'h0003_1002},  // R3 mask and force
    '{8'd3,  10'h000, 32'h0001_0000, 32'h0001_1002},  // R3
    '{8'd4,  10'h004, 32'h0000_0000, 32'h0200_0000},  // R4 ready forced
    '{8'd4,  10'h004, 32'h0000_0055, 32'h0200_0055},  // R4
    '{8'd2,  10'h008, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R2
    '{8'd2,  10'h00C, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    '{8'd2,  10'h010, 32'h0000_0000, 32'h0000_0000},
    '{8'd2,  10'h014, 32'h1234_5678, 32'h1234_5678},
    '{8'd2,  10'h018, 32'h0000_0003, 32'h0000_0003},
    '{8'd2,  10'h01C, 32'h0000_FFFF, 32'h0000_FFFF},
    '{8'd2,  10'h020, 32'h8000_0001, 32'h8000_0001},
    '{8'd2,  10'h024, 32'h0000_00B2, 32'h0000_00B2},
    '{8'd2,  10'h028, 32'hCAFE_F00D, 32'hCAFE_F00D},
    '{8'd2,  10'h02C, 32'h0000_0001, 32'h0000_0001},
    '{8'd2,  10'h030, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{8'd2,  10'h034, 32'h2000_1000, 32'h2000_1000},
    '{8'd5,  10'h040, 32'h0000_0000, 32'h0000_0000},  // R5 reads zero
    '{8'd9,  10'h044, 32'h0000_0000, 32'h0000_0000},  // R9 reads zero
    '{8'd10, 10'h3F0, 32'hFFFF_FFFF, 32'h0000_0000},  // R10 unmapped
    '{8'd10, 10'h038, 32'hFFFF_FFFF, 32'h0000_0000}   // R10 gap
  };

  localparam logic [31:0] RESET_EXP [14] = '{
    32'h0002_1002, 32'h3E14_0008, 32'h0003_F000, 32'h0000_0000,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0005, 32'h0000_0000,
    32'h0000_0000, 32'h0000_00A1, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0000
  };

  localparam logic [28:0] GROUP = 29'h1703_59E3;
  localparam logic [28:0] SOFT  = 29'h1703_59ED;

  logic [28:0] seen_rst;
  logic        seen_sys;
  logic [3:0]  seen_zero;
  logic [31:0] rd_val;
  logic        rd_vld;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    seen_rst  = periph_rst;
    seen_sys  = sys_rst_req;
    seen_zero = zero_req;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    rd_val = bus_rdata;
    rd_vld = bus_rvalid;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset values
    check("R1 periph_rst idle", {3'b0, periph_rst}, 32'h0);
    check("R1 sys_rst_req idle", {31'b0, sys_rst_req}, 32'h0);
    for (int i = 0; i < 14; i++) begin
      bus_read(10'(i * 4));
      check($sformatf("R1 reset value at %h", i * 4), rd_val, RESET_EXP[i]);
    end

    // R11 rvalid timing
    bus_read(10'h024);
    check("R11 rvalid after read", {31'b0, rd_vld}, 32'h1);
    @(negedge clk);
    check("R11 rvalid idle", {31'b0, bus_rvalid}, 32'h0);

    // Vector table: write then read back
    for (int v = 0; v < NV; v++) begin
      bus_write(VECS[v].addr, VECS[v].wdata);
      bus_read(VECS[v].addr);
      check($sformatf("R%0d readback at %h", VECS[v].req, VECS[v].addr), rd_val, VECS[v].exp);
    end

    // R5 plain pulse bits, single cycle
    bus_write(10'h040, 32'h0000_0810);
    check("R5 plain pulse", {3'b0, seen_rst}, 32'h0000_0810);
    check("R5 no system request", {31'b0, seen_sys}, 32'h0);
    @(negedge clk);
    check("R5 pulse ends", {3'b0, periph_rst}, 32'h0);
    bus_read(10'h040);
    check("R5 reads zero", rd_val, 32'h0);

    // R6 peripheral group
    bus_write(10'h040, 32'h4000_0001);
    check("R6 group mask", {3'b0, seen_rst}, {3'b0, GROUP});

    // R7 soft group, alone and winning
    bus_write(10'h040, 32'h2000_0000);
    check("R7 soft mask", {3'b0, seen_rst}, {3'b0, SOFT});
    bus_write(10'h040, 32'h6000_0000);
    check("R7 soft wins", {3'b0, seen_rst}, {3'b0, SOFT});

    // R8 system request
    bus_write(10'h040, 32'h8000_0000);
    check("R8 system request", {31'b0, seen_sys}, 32'h1);
    check("R8 no peripheral", {3'b0, seen_rst}, 32'h0);
    @(negedge clk);
    check("R8 request ends", {31'b0, sys_rst_req}, 32'h0);
    bus_write(10'h040, 32'hC000_0000);
    check("R8 with group sys", {31'b0, seen_sys}, 32'h1);
    check("R8 with group mask", {3'b0, seen_rst}, {3'b0, GROUP});

    // R9 zeroize banks
    bus_write(10'h044, 32'h0000_0005);
    check("R9 banks 0 and 2", {28'b0, seen_zero}, 32'h5);
    @(negedge clk);
    check("R9 request ends", {28'b0, zero_req}, 32'h0);
    bus_write(10'h044, 32'hFFFF_FFFF);
    check("R9 all banks", {28'b0, seen_zero}, 32'hF);

    // R10 misaligned accesses
    bus_write(10'h009, 32'h0000_0000);
    bus_read(10'h008);
    check("R10 misaligned write ignored", rd_val, 32'hDEAD_BEEF);
    bus_read(10'h009);
    check("R10 misaligned read zero", rd_val, 32'h0);
    bus_write(10'h041, 32'h8000_0810);
    check("R10 misaligned reset ignored", {3'b0, seen_rst}, 32'h0);
    check("R10 misaligned sys ignored", {31'b0, seen_sys}, 32'h0);
    bus_write(10'h3FC, 32'h0000_0000);
    bus_read(10'h000);
    check("R10 unmapped write ignored R3", rd_val, 32'h0001_1002);

    done = 1'b1;
    finish_run();
  end

endmodule